// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the controller-side sender of a time-multiplexed audio codec link. It runs on the bit clock that the codec drives. It produces two outputs: a frame marker and a serial data line. Each frame takes 256 bit clocks. It opens with a 16-bit tag slot, which lists the slots that carry meaningful content. Twelve 20-bit payload slots follow the tag. At the 12.288 MHz bit clock this gives a 48 kHz frame rate.

The frame takes its inputs at the clock edge where the frame starts:

- **Audio:** a stereo pair of 16-bit PCM samples, each with its own valid flag.
- **Register command (optional):** a read/write flag, a 7-bit register index and 16 bits of write data, offered on a request line.

An accepted command travels in the command-address and command-data slots. Once the command-data slot has been sent, the block answers with a one-cycle acknowledge. The requester then lowers its request. A request that arrives after a frame has started waits for the next frame.

Top module: `aclink_tx_framer`

## Requirements
- R1: A new frame starts every 256 bit clocks, so the marker rises exactly 256 cycles after its previous rise.
- R2: `frame_sync` is high for exactly the first 16 bit times of a frame (bit times 0 to 15) and low for bit times 16 to 255.
- R3: Tag slot (bit times 0 to 15, MSB first):
  - tag bit 15 is 1 when any slot is valid;
  - tag bit 14 flags slot 1 (command address);
  - tag bit 13 flags slot 2 (command data);
  - tag bit 12 flags slot 3 (left PCM);
  - tag bit 11 flags slot 4 (right PCM);
  - tag bits 10 to 3 are 0;
  - tag bits 2 to 0 equal the `CODEC_ID` parameter.
- R4: Slot 1 (bit times 16 to 35):
  - with an accepted command, bit 19 is the read flag (1 = read), bits 18 to 12 are the register index and bits 11 to 0 are 0;
  - with no command, the whole slot is 0.
- R5: Slot 2 (bit times 36 to 55) and its valid flag:
  - for an accepted write, the slot carries the write data in bits 19 to 4 and 0 in bits 3 to 0, and its valid flag is set;
  - for a read or no command, the slot is all zero with its flag clear, whatever `cmd_wdata` holds.
- R6: Slots 3 and 4 (bit times 56 to 75 and 76 to 95):
  - a slot whose valid input is high carries its sample in bits 19 to 4 and 0 in bits 3 to 0;
  - a slot whose valid input is low is all zero.
- R7: Slots 5 to 12 (bit times 96 to 255) are always zero.
- R8: Command handshake:
  - a request is taken only at a frame start;
  - `cmd_ack` is high for exactly one cycle, at bit time 56 of the frame that carried the command;
  - a request raised mid-frame yields no command slots and no acknowledge in that frame, and is served in the next.
- R9: Reset:
  - while `rst_n` is low, `frame_sync`, `sdata_out` and `cmd_ack` are 0;
  - the first rising edge after release starts a frame with bit time 0.
- R10: Outputs change only on the rising edge of `bit_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_left | input | 16 | Left PCM sample |
| pcm_left_valid | input | 1 | Left sample is to be sent |
| pcm_right | input | 16 | Right PCM sample |
| pcm_right_valid | input | 1 | Right sample is to be sent |
| cmd_req | input | 1 | Register command pending |
| cmd_read | input | 1 | 1 = read command, 0 = write |
| cmd_index | input | 7 | Register index |
| cmd_wdata | input | 16 | Write data |
| cmd_ack | output | 1 | One-cycle pulse after the command slots were sent |
| frame_sync | output | 1 | Frame marker, high during the tag slot |
| sdata_out | output | 1 | Serial frame data, MSB first |

## Verification
The embedded properties check on every cycle:
- the frame counter wraps to zero after a frame-start load;
- the marker rises only at bit time 0 and falls only at bit time 16;
- the acknowledge is a single pulse at bit time 56;
- the serializer shifts one bit per cycle between loads;
- a data-slot flag never appears without the address-slot flag.

The bench's scenarios show what no single-cycle relation can:
- the bit-exact content of every slot under each mix of sample and command inputs;
- the 256-cycle period;
- the deferral of a mid-frame request;
- the restart after a reset in the middle of a frame.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int SLOT_COUNT = 12;
    localparam int PCM_BITS   = 16;
    localparam int REG_BITS   = 7;
    localparam int DATA_BITS  = 16;

    typedef struct packed {
        logic                 read;
        logic [REG_BITS-1:0]  index;
        logic [DATA_BITS-1:0] wdata;
    } reg_cmd_t;
endpackage

// File: rtl/aclink_frame_count.sv
module aclink_frame_count #(
    parameter int FRAME_W = 256,
    parameter int TAG_W   = 16,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             sync
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sync;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        load      = (st_q.cnt == LAST);
        st_d.cnt  = load ? '0 : st_q.cnt + 1'b1;
        st_d.sync = (st_d.cnt < CNT_W'(TAG_W));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: LAST, sync: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign sync = st_q.sync;

    // R1: a load is always followed by bit time zero
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == '0));

    // R2: marker rises only at bit time 0 ...
    p_sync_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> (cnt == '0));

    // R2: ... and falls only at bit time TAG_W
    p_sync_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync) |-> (cnt == CNT_W'(TAG_W)));
endmodule

// File: rtl/aclink_serializer.sv
module aclink_serializer #(
    parameter int FRAME_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               sdo
);
    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
    } ser_state_t;

    ser_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.shreg = frame;
        end else begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo = st_q.shreg[FRAME_W-1];

    // R10: between loads the line carries the next lower bit, one per edge
    p_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (sdo == $past(st_q.shreg[FRAME_W-2])));
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
    import aclink_pkg::*;
#(
    parameter int CODEC_ID = 0,
    parameter int TAG_W    = TAG_BITS,
    parameter int SLOT_W   = SLOT_BITS,
    parameter int N_SLOTS  = SLOT_COUNT
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic [PCM_BITS-1:0]  pcm_left,
    input  logic                 pcm_left_valid,
    input  logic [PCM_BITS-1:0]  pcm_right,
    input  logic                 pcm_right_valid,
    input  logic                 cmd_req,
    input  logic                 cmd_read,
    input  logic [REG_BITS-1:0]  cmd_index,
    input  logic [DATA_BITS-1:0] cmd_wdata,
    output logic                 cmd_ack,
    output logic                 frame_sync,
    output logic                 sdata_out
);
    localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int ACK_AT  = TAG_W + 2 * SLOT_W;
    localparam int PAD_PCM = SLOT_W - PCM_BITS;
    localparam int PAD_DAT = SLOT_W - DATA_BITS;
    localparam int PAD_ADR = SLOT_W - 1 - REG_BITS;
    localparam int RSV_TAG = TAG_W - 1 - N_SLOTS - 3;

    typedef struct packed {
        logic busy;
        logic ack;
    } hs_state_t;

    logic [CNT_W-1:0]   cnt;
    logic               load;
    logic [FRAME_W-1:0] frame;
    logic [SLOT_W-1:0]  slot [N_SLOTS];
    logic [N_SLOTS-1:0] slot_vld;
    reg_cmd_t           cmd;
    hs_state_t          st_d, st_q;

    assign cmd = '{read: cmd_read, index: cmd_index, wdata: cmd_wdata};

    // frame assembly, evaluated every cycle, captured on load
    always_comb begin
        slot_vld    = '0;
        slot_vld[0] = cmd_req;
        slot_vld[1] = cmd_req && !cmd.read;
        slot_vld[2] = pcm_left_valid;
        slot_vld[3] = pcm_right_valid;
        for (int i = 0; i < N_SLOTS; i++) begin
            slot[i] = '0;
        end
        if (slot_vld[0]) slot[0] = {cmd.read, cmd.index, {PAD_ADR{1'b0}}};
        if (slot_vld[1]) slot[1] = {cmd.wdata, {PAD_DAT{1'b0}}};
        if (slot_vld[2]) slot[2] = {pcm_left, {PAD_PCM{1'b0}}};
        if (slot_vld[3]) slot[3] = {pcm_right, {PAD_PCM{1'b0}}};
        frame = '0;
        frame[FRAME_W-1 -: TAG_W] = {(|slot_vld), slot_vld[0], slot_vld[1],
                                     slot_vld[2], slot_vld[3],
                                     slot_vld[N_SLOTS-1:4],
                                     {RSV_TAG{1'b0}}, 3'(CODEC_ID)};
        for (int i = 0; i < N_SLOTS; i++) begin
            frame[FRAME_W-TAG_W-1-i*SLOT_W -: SLOT_W] = slot[i];
        end
    end

    // command handshake
    always_comb begin
        st_d      = st_q;
        st_d.ack  = st_q.busy && (cnt == CNT_W'(ACK_AT - 1));
        if (load) begin
            st_d.busy = cmd_req;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ack = st_q.ack;

    aclink_frame_count #(.FRAME_W(FRAME_W), .TAG_W(TAG_W)) u_count (
        .clk  (bit_clk),
        .rst_n(rst_n),
        .cnt  (cnt),
        .load (load),
        .sync (frame_sync)
    );

    aclink_serializer #(.FRAME_W(FRAME_W)) u_ser (
        .clk  (bit_clk),
        .rst_n(rst_n),
        .load (load),
        .frame(frame),
        .sdo  (sdata_out)
    );

    // R8: acknowledge is a single-cycle pulse
    p_ack_once_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        cmd_ack |=> !cmd_ack);

    // R8: acknowledge lands on the first bit time after the data slot
    p_ack_pos_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        cmd_ack |-> (cnt == CNT_W'(ACK_AT)));

    // R5: a data slot is never flagged without its address slot
    p_data_needs_addr_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |-> (!frame[FRAME_W-3] || frame[FRAME_W-2]));
endmodule

// File: tb/sim_aclink_tx_framer.sv
module sim_aclink_tx_framer;
    localparam int CLK_PERIOD = 82;
    localparam int CODEC      = 5;

    typedef struct packed {
        logic        lv;
        logic        rv;
        logic [15:0] l;
        logic [15:0] r;
        logic        req;
        logic        rd;
        logic [6:0]  idx;
        logic [15:0] wd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 7'h00, 16'h0000},
        '{1'b1, 1'b0, 16'h8001, 16'hFFFF, 1'b0, 1'b0, 7'h00, 16'h0000},
        '{1'b1, 1'b1, 16'h1234, 16'hABCD, 1'b1, 1'b0, 7'h2C, 16'hBEEF},
        '{1'b0, 1'b0, 16'h5555, 16'h5555, 1'b1, 1'b1, 7'h7F, 16'hFFFF},
        '{1'b0, 1'b1, 16'h0000, 16'h0001, 1'b1, 1'b0, 7'h00, 16'h0000},
        '{1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 7'h01, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pcm_left = '0, pcm_right = '0;
    logic        pcm_left_valid = 1'b0, pcm_right_valid = 1'b0;
    logic        cmd_req = 1'b0, cmd_read = 1'b0;
    logic [6:0]  cmd_index = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_ack, frame_sync, sdata_out;

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    aclink_tx_framer #(.CODEC_ID(CODEC)) u0 (
        .bit_clk(clk), .rst_n(rst_n),
        .pcm_left(pcm_left), .pcm_left_valid(pcm_left_valid),
        .pcm_right(pcm_right), .pcm_right_valid(pcm_right_valid),
        .cmd_req(cmd_req), .cmd_read(cmd_read), .cmd_index(cmd_index),
        .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
        .frame_sync(frame_sync), .sdata_out(sdata_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_frame(input vec_t v);
        logic [15:0]  tag;
        logic [19:0]  s1, s2, s3, s4;
        tag = {(v.req | v.lv | v.rv), v.req, (v.req & ~v.rd), v.lv, v.rv,
               8'h00, 3'(CODEC)};
        s1  = v.req ? {v.rd, v.idx, 12'h000} : 20'h0;
        s2  = (v.req && !v.rd) ? {v.wd, 4'h0} : 20'h0;
        s3  = v.lv ? {v.l, 4'h0} : 20'h0;
        s4  = v.rv ? {v.r, 4'h0} : 20'h0;
        return {tag, s1, s2, s3, s4, 160'h0};
    endfunction

    task automatic apply(input vec_t v);
        pcm_left_valid  = v.lv;
        pcm_right_valid = v.rv;
        pcm_left        = v.l;
        pcm_right       = v.r;
        cmd_req         = v.req;
        cmd_read        = v.rd;
        cmd_index       = v.idx;
        cmd_wdata       = v.wd;
    endtask

    // waits for a marker rise, then records one frame; request dropped on ack
    task automatic get_frame(input int raise_at, output logic [255:0] f,
                             output int sync_bad, output int ack_pos,
                             output longint rise);
        logic prev;
        sync_bad = 0;
        ack_pos  = -1;
        do begin
            prev = frame_sync;
            @(negedge clk);
        end while (!(frame_sync && !prev));
        rise = cyc;
        for (int k = 0; k < 256; k++) begin
            if (k > 0) @(negedge clk);
            f[255-k] = sdata_out;
            if (frame_sync !== (k < 16)) sync_bad++;
            if (cmd_ack) begin
                ack_pos = (ack_pos == -1) ? k : -2;
                cmd_req = 1'b0;
            end
            if (k == raise_at) cmd_req = 1'b1;
        end
    endtask

    task automatic check_frame(input string tagname, input logic [255:0] f,
                               input logic [255:0] e);
        $display("  frame %s", tagname);
        chk("R3 tag slot",          64'(f[255:240]), 64'(e[255:240]));
        chk("R4 command address",   64'(f[239:220]), 64'(e[239:220]));
        chk("R5 command data",      64'(f[219:200]), 64'(e[219:200]));
        chk("R6 left/right PCM",    64'(f[199:160]), 64'(e[199:160]));
        chk("R7 unused slots zero", 64'(|f[159:0]),  64'(|e[159:0]));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [255:0] f;
        int           sb, ap;
        longint       r0, r1;
        vec_t         v;

        // R9: outputs quiet while in reset
        repeat (4) @(negedge clk);
        chk("R9 sync in reset", 64'(frame_sync), 64'd0);
        chk("R9 sdo in reset",  64'(sdata_out),  64'd0);
        chk("R9 ack in reset",  64'(cmd_ack),    64'd0);

        apply(VECS[0]);
        rst_n = 1'b1;

        // vector table: R3-R8 and R2 per frame
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            get_frame(-1, f, sb, ap, r0);
            check_frame($sformatf("vector %0d", i), f, exp_frame(VECS[i]));
            chk("R2 marker over tag only", 64'(sb), 64'd0);
            chk("R8 ack position", 64'(ap), VECS[i].req ? 64'd56 : 64'hFFFF_FFFF_FFFF_FFFF);
        end

        // R1: period of 256 cycles across back-to-back frames
        apply(VECS[1]);
        get_frame(-1, f, sb, ap, r0);
        get_frame(-1, f, sb, ap, r1);
        chk("R1 frame period", 64'(r1 - r0), 64'd256);

        // R8: request raised mid-frame waits for the next frame
        v = '{1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 7'h33, 16'hC0DE};
        apply(v);
        get_frame(100, f, sb, ap, r0);
        chk("R8 late request not sent", 64'(f[254]), 64'd0);
        chk("R8 late request no ack", 64'(ap), 64'hFFFF_FFFF_FFFF_FFFF);
        v.req = 1'b1;
        get_frame(-1, f, sb, ap, r0);
        check_frame("deferred write", f, exp_frame(v));
        chk("R8 deferred ack", 64'(ap), 64'd56);

        // R9: reset in mid-frame, restart on first edge after release
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R9 async reset sync", 64'(frame_sync), 64'd0);
        chk("R9 async reset sdo",  64'(sdata_out),  64'd0);
        repeat (3) @(negedge clk);
        apply(VECS[1]);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 restart marker", 64'(frame_sync), 64'd1);
        chk("R9 restart tag bit 15", 64'(sdata_out), 64'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule